// File: doc/BRIEF.md
# UART FIFO Trigger and DMA-Ready Controller

This block sits beside the serial engine of one UART channel. It owns two byte queues, one for received characters and one for characters waiting to go out. An 8-bit control word sets how both queues behave: whether they are enabled, one-shot clears for each queue, the DMA signalling style, and the fill thresholds. The shifters push into and pop from the queues, and the receive side also raises a one-cycle timeout pulse when a character has been left waiting.

From the queue occupancy and the selected thresholds, the block produces a trigger flag for each direction and two active-low DMA request lines. In the simple DMA style, the request lines follow queue occupancy directly. In the burst style, a request is latched once a threshold is crossed. The receive request then stays asserted until the queue is drained. The transmit request stays asserted until the queue is full. Thresholds normally come from 2-bit codes in the control word. Four separate level registers can replace them: if any one of the four is nonzero, the receive and transmit thresholds are taken from the first two registers.

Top module: `uart_fifo_dma_ctl`

## Requirements
- R1: After reset both queues are empty, with count 0, and both overrun flags are 0. Both queues are disabled and the simple DMA style is selected, so rx_rdy_n=1, tx_rdy_n=0, rx_trig=0 and tx_trig=0.
- R2: Control bit 0 enables the queues. With bit 0 = 1, each queue holds DEPTH (32) bytes. With bit 0 = 0, each queue holds a single byte. A control write that changes bit 0 empties both queues.
- R3: A control write with bit 1 = 1 empties the receive queue and clears its overrun flag. The bit is not retained, so pushes that follow accumulate normally.
- R4: A control write with bit 2 = 1 empties the transmit queue and clears its overrun flag. The bit is not retained.
- R5: Receive threshold from control bits 7:6, with code 00→8, 01→16, 10→24 and 11→28. rx_trig=1 exactly when the queues are enabled, the receive count is nonzero and the count is at or above the threshold.
- R6: Transmit threshold from control bits 5:4, with code 00→16, 01→8, 10→24 and 11→30. tx_trig=1 exactly when the queues are enabled and the free entries (DEPTH minus count) are at or above the threshold.
- R7: The level registers are selected by lvl_sel: 0 is receive, 1 is transmit, 2 is flow-high and 3 is flow-low. While any of the four is nonzero, the receive threshold is register 0 and the transmit threshold is register 1, in place of the control codes.
- R8: The burst style is active when control bit 0 = 1 and bit 3 = 1. In this style, rx_rdy_n goes low in the same cycle that rx_trig or rx_timeout is high while the receive queue is not empty. It then stays low until the queue is empty.
- R9: In the burst style, tx_rdy_n goes low in the same cycle that tx_trig is high while the transmit queue is not full. It stays low until the queue is full, and it is high whenever the queue is full.
- R10: Outside the burst style, rx_rdy_n is low exactly when the receive queue holds a byte, and tx_rdy_n is low exactly when the transmit queue is empty.
- R11: A push to a full queue is dropped and sets that queue's sticky overrun flag. A pop from an empty queue leaves the count and the data output unchanged.
- R12: Bytes leave each queue in push order. The data output takes the oldest byte at the clock edge of an accepted pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word value |
| lvl_wr | input | 1 | Level register write strobe |
| lvl_sel | input | 2 | Level register select (0 rx, 1 tx, 2 flow-high, 3 flow-low) |
| lvl_wdata | input | LVL_W (8) | Level register value |
| rx_push | input | 1 | Push a received byte |
| rx_din | input | DW (8) | Received byte |
| rx_pop | input | 1 | Pop the oldest received byte |
| rx_timeout | input | 1 | Receive timeout pulse |
| tx_push | input | 1 | Push a byte to transmit |
| tx_din | input | DW (8) | Byte to transmit |
| tx_pop | input | 1 | Pop the oldest transmit byte |
| rx_dout | output | DW (8) | Last popped received byte |
| rx_count | output | CW (6) | Receive queue occupancy |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue at capacity |
| rx_overrun | output | 1 | Sticky receive overrun |
| tx_dout | output | DW (8) | Last popped transmit byte |
| tx_count | output | CW (6) | Transmit queue occupancy |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue at capacity |
| tx_overrun | output | 1 | Sticky transmit overrun |
| rx_trig | output | 1 | Receive threshold reached |
| tx_trig | output | 1 | Transmit threshold reached |
| rx_rdy_n | output | 1 | Active-low receive DMA request |
| tx_rdy_n | output | 1 | Active-low transmit DMA request |

## Verification
A wrong pointer or count shows at the ports on the very next edge, either as a count off by one or as a data byte out of order. It is caught the first time the queue is popped. A wrong entry in a threshold table, or a level override that does not take effect, shows as a trigger flag flipping one push too early or too late. Sweeping each code while filling and draining pins the error to one count value. A latch that releases early or late shows in the burst style as a request line that rises before the queue drains, or stays low past full. A comparison at every cycle catches this within the cycle it happens.

// File: rtl/ufd_pkg.sv
package ufd_pkg;

   typedef enum logic [1:0] {
      LVL_RX      = 2'd0,
      LVL_TX      = 2'd1,
      LVL_FLOW_HI = 2'd2,
      LVL_FLOW_LO = 2'd3
   } lvl_sel_e;

   // Control word bit positions (decoded by the queue and ready logic)
   localparam int CTL_EN    = 0;
   localparam int CTL_RXCLR = 1;
   localparam int CTL_TXCLR = 2;
   localparam int CTL_DMA   = 3;

   // Receive threshold decode: nonuniform steps
   function automatic logic [7:0] rx_table(input logic [1:0] code);
      case (code)
         2'd0:    return 8'd8;
         2'd1:    return 8'd16;
         2'd2:    return 8'd24;
         default: return 8'd28;
      endcase
   endfunction

   // Transmit threshold decode: codes 0 and 1 swap relative to receive
   function automatic logic [7:0] tx_table(input logic [1:0] code);
      case (code)
         2'd0:    return 8'd16;
         2'd1:    return 8'd8;
         2'd2:    return 8'd24;
         default: return 8'd30;
      endcase
   endfunction

endpackage

// File: rtl/ufd_fifo.sv
module ufd_fifo #(
   parameter  int DEPTH = 32,
   parameter  int DW    = 8,
   localparam int AW    = $clog2(DEPTH),
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          en,
   input  logic          push,
   input  logic [DW-1:0] din,
   input  logic          pop,
   output logic [DW-1:0] dout,
   output logic [CW-1:0] count,
   output logic          empty,
   output logic          full,
   output logic          overrun
);

   if ((1 << AW) != DEPTH || DEPTH < 2) begin : g_bad_depth
      $error("ufd_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic          push_ok, pop_ok;

   assign empty   = (count == '0);
   assign full    = en ? (count == CW'(DEPTH)) : !empty;
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;

   always_ff @(posedge clk) begin
      if (push_ok && !flush) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         count   <= '0;
         overrun <= 1'b0;
         dout    <= '0;
      end else if (flush) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         count   <= '0;
         overrun <= 1'b0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok) begin
            dout   <= mem[rd_ptr];
            rd_ptr <= rd_ptr + 1'b1;
         end
         if (push && full) overrun <= 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      int'(count) <= DEPTH);
   p_drop_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !flush) |=> ($stable(count) && overrun));
   p_empty_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !flush) |=> $stable(dout));

endmodule

// File: rtl/ufd_trig_sel.sv
module ufd_trig_sel
   import ufd_pkg::*;
#(
   parameter  int DEPTH       = 32,
   parameter  int LVL_W       = 8,
   parameter  bit PROG_LEVELS = 1'b1,
   localparam int CW          = $clog2(DEPTH + 1)
) (
   input  logic             en,
   input  logic [1:0]       rx_code,
   input  logic [1:0]       tx_code,
   input  logic [LVL_W-1:0] lvl_rx,
   input  logic [LVL_W-1:0] lvl_tx,
   input  logic [LVL_W-1:0] lvl_fhi,
   input  logic [LVL_W-1:0] lvl_flo,
   input  logic [CW-1:0]    rx_count,
   input  logic [CW-1:0]    tx_count,
   output logic             rx_trig,
   output logic             tx_trig
);

   logic [LVL_W-1:0] rx_lvl, tx_lvl;
   int               tx_free;

   if (PROG_LEVELS) begin : g_prog
      logic use_prog;
      assign use_prog = |{lvl_rx, lvl_tx, lvl_fhi, lvl_flo};
      assign rx_lvl   = use_prog ? lvl_rx : LVL_W'(rx_table(rx_code));
      assign tx_lvl   = use_prog ? lvl_tx : LVL_W'(tx_table(tx_code));
   end else begin : g_fixed
      assign rx_lvl = LVL_W'(rx_table(rx_code));
      assign tx_lvl = LVL_W'(tx_table(tx_code));
   end

   assign tx_free = DEPTH - int'(tx_count);
   assign rx_trig = en && (rx_count != '0) && (int'(rx_count) >= int'(rx_lvl));
   assign tx_trig = en && (tx_free >= int'(tx_lvl));

endmodule

// File: rtl/ufd_rdy_gen.sv
module ufd_rdy_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic mode1,
   input  logic rx_flush,
   input  logic tx_flush,
   input  logic rx_trig,
   input  logic tx_trig,
   input  logic rx_timeout,
   input  logic rx_empty,
   input  logic tx_empty,
   input  logic tx_full,
   output logic rx_rdy_n,
   output logic tx_rdy_n
);

   logic rx_act, tx_act;
   logic rx_req, tx_req;

   // Latched request: set by trigger/timeout, released by empty (rx) or full (tx)
   assign rx_req = (rx_act || rx_trig || rx_timeout) && !rx_empty;
   assign tx_req = (tx_act || tx_trig) && !tx_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_act <= 1'b0;
         tx_act <= 1'b0;
      end else begin
         rx_act <= mode1 && rx_req && !rx_flush;
         tx_act <= mode1 && tx_req && !tx_flush;
      end
   end

   assign rx_rdy_n = mode1 ? !rx_req : rx_empty;
   assign tx_rdy_n = mode1 ? !tx_req : !tx_empty;

   p_rx_empty_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_empty |-> rx_rdy_n);
   p_tx_full_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode1 && tx_full) |-> tx_rdy_n);
   p_rx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode1 && !rx_rdy_n && !rx_flush) |=> (!mode1 || rx_empty || !rx_rdy_n));
   p_tx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode1 && !tx_rdy_n && !tx_flush) |=> (!mode1 || tx_full || !tx_rdy_n));

endmodule

// File: rtl/uart_fifo_dma_ctl.sv
module uart_fifo_dma_ctl
   import ufd_pkg::*;
#(
   parameter  int DEPTH       = 32,
   parameter  int DW          = 8,
   parameter  int LVL_W       = 8,
   parameter  bit PROG_LEVELS = 1'b1,
   localparam int CW          = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic [7:0]       ctl_wdata,
   input  logic             lvl_wr,
   input  logic [1:0]       lvl_sel,
   input  logic [LVL_W-1:0] lvl_wdata,
   input  logic             rx_push,
   input  logic [DW-1:0]    rx_din,
   input  logic             rx_pop,
   input  logic             rx_timeout,
   input  logic             tx_push,
   input  logic [DW-1:0]    tx_din,
   input  logic             tx_pop,
   output logic [DW-1:0]    rx_dout,
   output logic [CW-1:0]    rx_count,
   output logic             rx_empty,
   output logic             rx_full,
   output logic             rx_overrun,
   output logic [DW-1:0]    tx_dout,
   output logic [CW-1:0]    tx_count,
   output logic             tx_empty,
   output logic             tx_full,
   output logic             tx_overrun,
   output logic             rx_trig,
   output logic             tx_trig,
   output logic             rx_rdy_n,
   output logic             tx_rdy_n
);

   if (DEPTH < 32) begin : g_bad_depth
      $error("uart_fifo_dma_ctl: DEPTH must cover the largest table threshold");
   end
   if (LVL_W < 5) begin : g_bad_lvl
      $error("uart_fifo_dma_ctl: LVL_W too narrow for table thresholds");
   end

   logic             en_q, dma_q;
   logic [1:0]       rx_code_q, tx_code_q;
   logic [LVL_W-1:0] lvl_q [4];
   logic             en_change, rx_flush, tx_flush, mode1;

   assign en_change = ctl_wr && (ctl_wdata[CTL_EN] != en_q);
   assign rx_flush  = (ctl_wr && ctl_wdata[CTL_RXCLR]) || en_change;
   assign tx_flush  = (ctl_wr && ctl_wdata[CTL_TXCLR]) || en_change;
   assign mode1     = en_q && dma_q;

   // Clear bits are strobes only; remaining fields are held
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         dma_q     <= 1'b0;
         rx_code_q <= '0;
         tx_code_q <= '0;
      end else if (ctl_wr) begin
         en_q      <= ctl_wdata[CTL_EN];
         dma_q     <= ctl_wdata[CTL_DMA];
         tx_code_q <= ctl_wdata[5:4];
         rx_code_q <= ctl_wdata[7:6];
      end
   end

   for (genvar i = 0; i < 4; i++) begin : g_lvl
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        lvl_q[i] <= '0;
         else if (lvl_wr && lvl_sel == 2'(i)) lvl_q[i] <= lvl_wdata;
      end
   end

   ufd_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(rx_flush), .en(en_q),
      .push(rx_push), .din(rx_din), .pop(rx_pop), .dout(rx_dout),
      .count(rx_count), .empty(rx_empty), .full(rx_full), .overrun(rx_overrun));

   ufd_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txq (
      .clk(clk), .rst_n(rst_n), .flush(tx_flush), .en(en_q),
      .push(tx_push), .din(tx_din), .pop(tx_pop), .dout(tx_dout),
      .count(tx_count), .empty(tx_empty), .full(tx_full), .overrun(tx_overrun));

   ufd_trig_sel #(.DEPTH(DEPTH), .LVL_W(LVL_W), .PROG_LEVELS(PROG_LEVELS)) u_trig (
      .en(en_q), .rx_code(rx_code_q), .tx_code(tx_code_q),
      .lvl_rx(lvl_q[LVL_RX]), .lvl_tx(lvl_q[LVL_TX]),
      .lvl_fhi(lvl_q[LVL_FLOW_HI]), .lvl_flo(lvl_q[LVL_FLOW_LO]),
      .rx_count(rx_count), .tx_count(tx_count),
      .rx_trig(rx_trig), .tx_trig(tx_trig));

   ufd_rdy_gen u_rdy (
      .clk(clk), .rst_n(rst_n), .mode1(mode1),
      .rx_flush(rx_flush), .tx_flush(tx_flush),
      .rx_trig(rx_trig), .tx_trig(tx_trig), .rx_timeout(rx_timeout),
      .rx_empty(rx_empty), .tx_empty(tx_empty), .tx_full(tx_full),
      .rx_rdy_n(rx_rdy_n), .tx_rdy_n(tx_rdy_n));

   p_rx_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && ctl_wdata[CTL_RXCLR]) |=> (rx_count == '0 && !rx_overrun));
   p_tx_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && ctl_wdata[CTL_TXCLR]) |=> (tx_count == '0 && !tx_overrun));
   p_single_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> (int'(rx_count) <= 1 && int'(tx_count) <= 1));

endmodule

// File: tb/uart_fifo_dma_ctl_tb.sv
module uart_fifo_dma_ctl_tb;

   localparam int DEPTH = 32;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_wr = 0, lvl_wr = 0;
   logic [7:0] ctl_wdata = 0, lvl_wdata = 0;
   logic [1:0] lvl_sel = 0;
   logic       rx_push = 0, rx_pop = 0, rx_timeout = 0, tx_push = 0, tx_pop = 0;
   logic [7:0] rx_din = 0, tx_din = 0;
   logic [7:0] rx_dout, tx_dout;
   logic [5:0] rx_count, tx_count;
   logic       rx_empty, rx_full, rx_overrun, tx_empty, tx_full, tx_overrun;
   logic       rx_trig, tx_trig, rx_rdy_n, tx_rdy_n;

   always #4 clk = ~clk;

   uart_fifo_dma_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .lvl_wr(lvl_wr), .lvl_sel(lvl_sel), .lvl_wdata(lvl_wdata),
      .rx_push(rx_push), .rx_din(rx_din), .rx_pop(rx_pop), .rx_timeout(rx_timeout),
      .tx_push(tx_push), .tx_din(tx_din), .tx_pop(tx_pop),
      .rx_dout(rx_dout), .rx_count(rx_count), .rx_empty(rx_empty), .rx_full(rx_full),
      .rx_overrun(rx_overrun), .tx_dout(tx_dout), .tx_count(tx_count),
      .tx_empty(tx_empty), .tx_full(tx_full), .tx_overrun(tx_overrun),
      .rx_trig(rx_trig), .tx_trig(tx_trig), .rx_rdy_n(rx_rdy_n), .tx_rdy_n(tx_rdy_n));

   // Reference model state
   logic [7:0] rxq[$], txq[$];
   bit         m_en, m_dma, m_rxovr, m_txovr, m_rxact, m_txact;
   bit [1:0]   m_rxc, m_txc;
   int         m_lvl[4];
   logic [7:0] m_rxd, m_txd;
   int         n_chk = 0, n_bad = 0;
   bit         done = 0;

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int rxtab(bit [1:0] c);
      int t[4] = '{8, 16, 24, 28};
      return t[c];
   endfunction
   function automatic int txtab(bit [1:0] c);
      int t[4] = '{16, 8, 24, 30};
      return t[c];
   endfunction

   // Compare all outputs against the model, then advance the model by one edge
   task automatic step();
      int  rn, tn, cap, rl, tl;
      bit  ovr, rtr, ttr, m1, rreq, treq, fr, ft;
      #1;
      rn  = rxq.size();
      tn  = txq.size();
      cap = m_en ? DEPTH : 1;
      ovr = (m_lvl[0] | m_lvl[1] | m_lvl[2] | m_lvl[3]) != 0;
      rl  = ovr ? m_lvl[0] : rxtab(m_rxc);
      tl  = ovr ? m_lvl[1] : txtab(m_txc);
      rtr = m_en && rn > 0 && rn >= rl;
      ttr = m_en && (DEPTH - tn) >= tl;
      m1  = m_en && m_dma;
      rreq = (m_rxact || rtr || rx_timeout) && rn > 0;
      treq = (m_txact || ttr) && tn < cap;
      chk("R2 rx_count", rx_count, rn);
      chk("R2 tx_count", tx_count, tn);
      chk("R2 rx_full", rx_full, rn == cap);
      chk("R2 tx_full", tx_full, tn == cap);
      chk("R11 rx_empty", rx_empty, rn == 0);
      chk("R11 tx_empty", tx_empty, tn == 0);
      chk("R11 rx_overrun", rx_overrun, m_rxovr);
      chk("R11 tx_overrun", tx_overrun, m_txovr);
      chk("R12 rx_dout", rx_dout, m_rxd);
      chk("R12 tx_dout", tx_dout, m_txd);
      chk(ovr ? "R7 rx_trig" : "R5 rx_trig", rx_trig, rtr);
      chk(ovr ? "R7 tx_trig" : "R6 tx_trig", tx_trig, ttr);
      if (m1) begin
         chk("R8 rx_rdy_n", rx_rdy_n, !rreq);
         chk("R9 tx_rdy_n", tx_rdy_n, !treq);
      end else begin
         chk("R10 rx_rdy_n", rx_rdy_n, rn == 0);
         chk("R10 tx_rdy_n", tx_rdy_n, tn != 0);
      end
      // next state
      fr = ctl_wr && (ctl_wdata[1] || ctl_wdata[0] != m_en);
      ft = ctl_wr && (ctl_wdata[2] || ctl_wdata[0] != m_en);
      m_rxact = m1 && rreq && !fr;
      m_txact = m1 && treq && !ft;
      if (fr) begin rxq.delete(); m_rxovr = 0; end
      else begin
         if (rx_pop && rn > 0) m_rxd = rxq.pop_front();
         if (rx_push && rn < cap) rxq.push_back(rx_din);
         else if (rx_push) m_rxovr = 1;
      end
      if (ft) begin txq.delete(); m_txovr = 0; end
      else begin
         if (tx_pop && tn > 0) m_txd = txq.pop_front();
         if (tx_push && tn < cap) txq.push_back(tx_din);
         else if (tx_push) m_txovr = 1;
      end
      if (ctl_wr) begin
         m_en = ctl_wdata[0]; m_dma = ctl_wdata[3];
         m_txc = ctl_wdata[5:4]; m_rxc = ctl_wdata[7:6];
      end
      if (lvl_wr) m_lvl[lvl_sel] = lvl_wdata;
      @(posedge clk);
      @(negedge clk);
      ctl_wr = 0; lvl_wr = 0; rx_push = 0; rx_pop = 0; rx_timeout = 0;
      tx_push = 0; tx_pop = 0;
   endtask

   task automatic wctl(logic [7:0] v);
      ctl_wr = 1; ctl_wdata = v; step();
   endtask
   task automatic wlvl(int s, int v);
      lvl_wr = 1; lvl_sel = 2'(s); lvl_wdata = 8'(v); step();
   endtask
   task automatic rxp(int v);  rx_push = 1; rx_din = 8'(v); step(); endtask
   task automatic txp(int v);  tx_push = 1; tx_din = 8'(v); step(); endtask
   task automatic rxo();       rx_pop = 1; step(); endtask
   task automatic txo();       tx_pop = 1; step(); endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual 0 expected 1 (run completed)");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int unsigned seed = 32'h1234_5678;
      m_rxd = 0; m_txd = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      chk("R1 rx_count", rx_count, 0);
      chk("R1 tx_count", tx_count, 0);
      chk("R1 rx_rdy_n", rx_rdy_n, 1);
      chk("R1 tx_rdy_n", tx_rdy_n, 0);
      chk("R1 rx_trig", rx_trig, 0);
      chk("R1 overrun", rx_overrun | tx_overrun, 0);
      step();

      // Disabled: single-byte holding, mode-0 ready (R2, R10, R11, R12)
      rxp(8'hA1);
      rxp(8'hA2);
      chk("R2 disabled rx holds one", rx_count, 1);
      chk("R11 overrun on full push", rx_overrun, 1);
      chk("R10 rx_rdy_n with byte", rx_rdy_n, 0);
      txp(8'h05);
      chk("R10 tx_rdy_n non-empty", tx_rdy_n, 1);
      rxo();
      chk("R12 first byte out", rx_dout, 8'hA1);
      rxo();
      chk("R11 empty pop keeps dout", rx_dout, 8'hA1);

      // Enable: flush on bit 0 change, full depth (R2, R11)
      wctl(8'h01);
      chk("R2 enable flushes tx", tx_count, 0);
      for (int i = 0; i < DEPTH + 1; i++) rxp(i + 8'h40);
      chk("R2 full depth", rx_count, DEPTH);
      for (int i = 0; i < DEPTH + 1; i++) rxo();

      // Clear strobes (R3, R4)
      for (int i = 0; i < 5; i++) begin rxp(i); txp(i + 8'h10); end
      wctl(8'h03);
      chk("R3 rx cleared", rx_count, 0);
      chk("R3 tx untouched", tx_count, 5);
      rxp(8'h77); rxp(8'h78);
      chk("R3 bit self-clears", rx_count, 2);
      wctl(8'h05);
      chk("R4 tx cleared", tx_count, 0);
      chk("R4 rx untouched", rx_count, 2);

      // Tables and burst DMA style (R5, R6, R8, R9)
      for (int c = 0; c < 4; c++) begin
         wctl({2'(c), 2'(c), 4'b1111});
         for (int i = 0; i < 30; i++) rxp(i * 3 + c);
         for (int i = 0; i < 31; i++) rxo();
         for (int i = 0; i < DEPTH + 1; i++) txp(i ^ 8'h5A);
         for (int i = 0; i < DEPTH + 1; i++) txo();
      end

      // Timeout latch (R8)
      rxp(8'hC1); rxp(8'hC2);
      rx_timeout = 1; step();
      chk("R8 latched after timeout", rx_rdy_n, 0);
      rxo();
      chk("R8 held until empty", rx_rdy_n, 0);
      rxo();
      chk("R8 released at empty", rx_rdy_n, 1);

      // Level register override (R7)
      wctl(8'hCF);
      wlvl(3, 5);
      rxp(8'h11);
      chk("R7 override rx level 0", rx_trig, 1);
      wlvl(0, 3); wlvl(1, 20);
      rxp(8'h12);
      chk("R7 below prog level", rx_trig, 0);
      rxp(8'h13);
      chk("R7 at prog level", rx_trig, 1);
      for (int i = 0; i < 14; i++) txp(i);
      chk("R7 tx free 18 < 20", tx_trig, 0);
      txo(); txo();
      chk("R7 tx free 20", tx_trig, 1);
      for (int i = 0; i < 4; i++) wlvl(i, 0);
      chk("R7 back to table", rx_trig, 0);

      // Mixed traffic
      for (int i = 0; i < 4000; i++) begin
         seed = seed * 1103515245 + 12345;
         rx_push = seed[16]; rx_din = seed[31:24];
         rx_pop = seed[17] & seed[18];
         tx_push = seed[19] & seed[20]; tx_din = seed[23:16];
         tx_pop = seed[21];
         rx_timeout = (seed[9:6] == 0);
         if (seed[15:11] == 0) begin
            ctl_wr = 1;
            ctl_wdata = {seed[29:26], 1'b1, seed[2] & seed[3], seed[4] & seed[5], !(seed[1] & seed[0] & seed[30])};
         end
         if (seed[15:10] == 6'h3F) begin
            lvl_wr = 1; lvl_sel = seed[23:22];
            lvl_wdata = seed[25] ? 8'(seed[28:24]) : 8'd0;
         end
         step();
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule